// File: doc/BRIEF.md
# SD Card SPI-Mode Bring-Up Sequencer

This block drives a memory card from power-up into SPI mode and leaves it ready for fixed-size block transfers. It does not shift any bits itself. Each step is handed to a separate command/response engine as a request. The request carries a command index, a 32-bit argument, a fixed check byte and the number of trailing response bytes. The engine answers with the first response status byte (R1), a timeout flag and the capacity flag taken from the trailing bytes of an operating-conditions read. One kind of request is the idle-clock burst, which sends filler bytes with chip select held high.

The sequencer resets the card and probes its version. It then polls the card until the card leaves its initialising state. The probe reply picks the path. On the older path the polling argument is zero. On the newer path the argument announces high-capacity support, each attempt first reads the operating conditions, and a programmable pause comes before every attempt. The sequencer then fixes the block length and releases the slow clock.

The result is a card-type code, a block-address multiplier (the block length for byte-addressed cards, 1 for block-addressed ones) and an error flag. A one-cycle done pulse marks the result.

Top module: `sd_init_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o and cmd_req_o are 0, card_type_o and addr_mult_o are 0, and slow_clk_o is 1. After start_i, the first request is an idle-clock burst (cmd_dummy_o=1, cmd_arg_o = DUMMY_BYTES). slow_clk_o stays 1 for every request of the sequence. Each request is a single-cycle pulse.
- R2: The reset command uses index 0, argument 0, check byte 0x95 and 0 trailing bytes. Any R1 other than 0x01 ends the sequence with err_o=1, card_type_o=0 (fail) and addr_mult_o=0, and no further request is issued.
- R3: The probe uses index 8, argument 0x000001AA, check byte 0x87 and 4 trailing bytes. R1=0x01 selects the newer path. R1=0x05 selects the older path. Any other value fails as in R2.
- R4: On the older path, each attempt is index 55 followed by index 41 with argument 0, and the R1 of index 55 is ignored. When index 41 returns 0x00, the card is type 1 and addr_mult_o = BLOCK_LEN.
- R5: On the newer path, each attempt is index 58 (4 trailing bytes), then 55, then 41 with argument 0x40000000. When 41 returns 0x00, one more index 58 is issued. The card is then type 3 if cmd_ccs_i is 1 with that reply and type 2 otherwise, with addr_mult_o = 1.
- R6: After MAX_TRIES index-41 replies that are not 0x00, the sequence fails with no further request.
- R7: On the newer path, at least WAIT_CYC clock cycles pass between the reply that ends the probe or a failed attempt and the next index-58 request.
- R8: After identification, index 16 is issued with argument BLOCK_LEN. A nonzero R1 fails the sequence. An R1 of zero ends it with err_o=0 and slow_clk_o=0.
- R9: A reply with cmd_tmo_i=1 at any step fails the sequence at once.
- R10: done_o is high for exactly one cycle at the end of the sequence, with busy_o low. err_o holds its value until the next start. A start_i pulse while busy_o is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the sequence (ignored while busy) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Sticky failure flag |
| card_type_o | output | 2 | 0 fail, 1 older standard, 2 newer standard, 3 newer high capacity |
| addr_mult_o | output | $clog2(BLOCK_LEN)+1 | Block-address multiplier |
| slow_clk_o | output | 1 | 1 selects the slow bring-up bit clock |
| cmd_req_o | output | 1 | One-cycle request to the command engine |
| cmd_dummy_o | output | 1 | Request is an idle-clock burst with chip select high |
| cmd_index_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument, or the burst byte count |
| cmd_crc_o | output | 8 | Check byte to send |
| cmd_tail_o | output | 3 | Trailing response bytes to collect |
| cmd_done_i | input | 1 | Engine reply valid |
| cmd_tmo_i | input | 1 | Reply is a timeout |
| cmd_r1_i | input | 8 | First response status byte |
| cmd_ccs_i | input | 1 | Capacity flag from the trailing bytes |

## Verification
A request rises one clock after the sequencer enters a command step and falls on the next edge. The bench's responder samples requests on falling edges, so each pulse is seen exactly once. A reply is consumed on the rising edge where cmd_done_i is high. On that same edge, done_o, err_o, card_type_o, addr_mult_o and slow_clk_o take their final values. The bench therefore checks them at the falling edge where done_o is first seen, then one falling edge later for the end of the pulse and the held flag. The pause on the newer path is measured in cycles, from the falling edge that presents a reply to the falling edge that sees the next index-58 request.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DUMMY,
      ST_RESET,
      ST_PROBE,
      ST_V1_APP,
      ST_V1_OP,
      ST_V2_WAIT,
      ST_V2_OCR,
      ST_V2_APP,
      ST_V2_OP,
      ST_V2_OCR_FIN,
      ST_BLKLEN
   } step_t;

   typedef enum logic [1:0] {
      CARD_NONE  = 2'd0,
      CARD_V1    = 2'd1,
      CARD_V2_SC = 2'd2,
      CARD_V2_HC = 2'd3
   } card_t;

   localparam logic [5:0] IX_RESET  = 6'd0;
   localparam logic [5:0] IX_PROBE  = 6'd8;
   localparam logic [5:0] IX_BLKLEN = 6'd16;
   localparam logic [5:0] IX_OPCOND = 6'd41;
   localparam logic [5:0] IX_APP    = 6'd55;
   localparam logic [5:0] IX_OCR    = 6'd58;

   localparam logic [7:0] R1_IDLE     = 8'h01;
   localparam logic [7:0] R1_IDLE_ILL = 8'h05;
   localparam logic [7:0] R1_READY    = 8'h00;

   localparam logic [31:0] PROBE_ARG = 32'h0000_01AA;
   localparam logic [31:0] HCS_ARG   = 32'h4000_0000;
   localparam logic [7:0]  CRC_FIXED = 8'h95;
   localparam logic [7:0]  CRC_PROBE = 8'h87;
   localparam logic [2:0]  TAIL_WORD = 3'd4;

   typedef struct packed {
      logic        dummy;
      logic [5:0]  index;
      logic [31:0] arg;
      logic [7:0]  crc;
      logic [2:0]  tail;
   } cmd_t;

endpackage

// File: rtl/sdi_cmd_rom.sv
module sdi_cmd_rom
   import sdi_pkg::*;
#(
   parameter int unsigned DUMMY_BYTES = 16,
   parameter int unsigned BLOCK_LEN   = 512
) (
   input  step_t step_i,
   output cmd_t  cmd_o
);

   always_comb begin
      cmd_o       = '0;
      cmd_o.crc   = CRC_FIXED;
      unique case (step_i)
         ST_DUMMY: begin
            cmd_o.dummy = 1'b1;
            cmd_o.arg   = 32'(DUMMY_BYTES);
            cmd_o.crc   = 8'hFF;
         end
         ST_RESET: cmd_o.index = IX_RESET;
         ST_PROBE: begin
            cmd_o.index = IX_PROBE;
            cmd_o.arg   = PROBE_ARG;
            cmd_o.crc   = CRC_PROBE;
            cmd_o.tail  = TAIL_WORD;
         end
         ST_V1_APP, ST_V2_APP: cmd_o.index = IX_APP;
         ST_V1_OP: cmd_o.index = IX_OPCOND;
         ST_V2_OP: begin
            cmd_o.index = IX_OPCOND;
            cmd_o.arg   = HCS_ARG;
         end
         ST_V2_OCR, ST_V2_OCR_FIN: begin
            cmd_o.index = IX_OCR;
            cmd_o.tail  = TAIL_WORD;
         end
         ST_BLKLEN: begin
            cmd_o.index = IX_BLKLEN;
            cmd_o.arg   = 32'(BLOCK_LEN);
         end
         default: cmd_o = '0;
      endcase
   end

endmodule

// File: rtl/sdi_tick_ctr.sv
module sdi_tick_ctr #(
   parameter int unsigned COUNT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic busy_o
);

   localparam int unsigned W = $clog2(COUNT + 1);
   localparam logic [W-1:0] LOAD_VAL = W'(COUNT);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= LOAD_VAL;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

   // R7
   tick_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> busy_o);

endmodule

// File: rtl/sdi_try_ctr.sv
module sdi_try_ctr #(
   parameter int unsigned MAX_TRIES = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);

   localparam int unsigned W = $clog2(MAX_TRIES + 1);
   localparam logic [W-1:0] LAST_VAL = W'(MAX_TRIES - 1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr_i)
         cnt_q <= '0;
      else if (inc_i)
         cnt_q <= cnt_q + 1'b1;
   end

   assign last_o = (cnt_q == LAST_VAL);

   // R6
   try_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc_i |-> !last_o);

endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq
   import sdi_pkg::*;
#(
   parameter int unsigned DUMMY_BYTES = 16,
   parameter int unsigned MAX_TRIES   = 5000,
   parameter int unsigned WAIT_CYC    = 5000,
   parameter int unsigned BLOCK_LEN   = 512,
   localparam int unsigned MULT_W     = $clog2(BLOCK_LEN) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [1:0]        card_type_o,
   output logic [MULT_W-1:0] addr_mult_o,
   output logic              slow_clk_o,
   output logic              cmd_req_o,
   output logic              cmd_dummy_o,
   output logic [5:0]        cmd_index_o,
   output logic [31:0]       cmd_arg_o,
   output logic [7:0]        cmd_crc_o,
   output logic [2:0]        cmd_tail_o,
   input  logic              cmd_done_i,
   input  logic              cmd_tmo_i,
   input  logic [7:0]        cmd_r1_i,
   input  logic              cmd_ccs_i
);

   initial begin
      assert (MAX_TRIES >= 1) else $error("MAX_TRIES must be at least 1");
      assert (DUMMY_BYTES >= 1) else $error("DUMMY_BYTES must be at least 1");
      assert (BLOCK_LEN >= 2 && (BLOCK_LEN & (BLOCK_LEN - 1)) == 0)
         else $error("BLOCK_LEN must be a power of two");
   end

   step_t             state;
   step_t             nxt;
   logic              sent_q, req_q, go_q, done_q, err_q, slow_q;
   card_t             type_q;
   logic [MULT_W-1:0] mult_q;
   logic              bad, try_inc, try_last, wait_busy, resp_ev;
   cmd_t              cmd;

   sdi_cmd_rom #(.DUMMY_BYTES(DUMMY_BYTES), .BLOCK_LEN(BLOCK_LEN)) u_rom (
      .step_i (state),
      .cmd_o  (cmd)
   );

   sdi_try_ctr #(.MAX_TRIES(MAX_TRIES)) u_try (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (state == ST_IDLE && start_i),
      .inc_i  (resp_ev && try_inc && !bad),
      .last_o (try_last)
   );

   generate
      if (WAIT_CYC == 0) begin : g_nowait
         assign wait_busy = 1'b0;
      end else begin : g_wait
         sdi_tick_ctr #(.COUNT(WAIT_CYC)) u_tick (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (go_q),
            .busy_o (wait_busy)
         );
      end
   endgenerate

   assign resp_ev = sent_q && cmd_done_i;

   // reply decode: next step, failure and attempt bookkeeping
   always_comb begin
      nxt     = state;
      bad     = 1'b0;
      try_inc = 1'b0;
      unique case (state)
         ST_DUMMY: nxt = ST_RESET;
         ST_RESET: begin
            if (cmd_r1_i == R1_IDLE) nxt = ST_PROBE;
            else                     bad = 1'b1;
         end
         ST_PROBE: begin
            if (cmd_r1_i == R1_IDLE)          nxt = ST_V2_WAIT;
            else if (cmd_r1_i == R1_IDLE_ILL) nxt = ST_V1_APP;
            else                              bad = 1'b1;
         end
         ST_V1_APP: nxt = ST_V1_OP;
         ST_V1_OP: begin
            if (cmd_r1_i == R1_READY) nxt = ST_BLKLEN;
            else if (try_last)        bad = 1'b1;
            else begin
               try_inc = 1'b1;
               nxt     = ST_V1_APP;
            end
         end
         ST_V2_OCR: nxt = ST_V2_APP;
         ST_V2_APP: nxt = ST_V2_OP;
         ST_V2_OP: begin
            if (cmd_r1_i == R1_READY) nxt = ST_V2_OCR_FIN;
            else if (try_last)        bad = 1'b1;
            else begin
               try_inc = 1'b1;
               nxt     = ST_V2_WAIT;
            end
         end
         ST_V2_OCR_FIN: nxt = ST_BLKLEN;
         ST_BLKLEN: begin
            if (cmd_r1_i == R1_READY) nxt = ST_IDLE;
            else                      bad = 1'b1;
         end
         default: nxt = state;
      endcase
      if (cmd_tmo_i) bad = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         sent_q <= 1'b0;
         req_q  <= 1'b0;
         go_q   <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         slow_q <= 1'b1;
         type_q <= CARD_NONE;
         mult_q <= '0;
      end else begin
         req_q  <= 1'b0;
         go_q   <= 1'b0;
         done_q <= 1'b0;
         if (state == ST_IDLE) begin
            if (start_i) begin
               state  <= ST_DUMMY;
               sent_q <= 1'b0;
               err_q  <= 1'b0;
               slow_q <= 1'b1;
               type_q <= CARD_NONE;
               mult_q <= '0;
            end
         end else if (state == ST_V2_WAIT) begin
            if (!go_q && !wait_busy) state <= ST_V2_OCR;
         end else if (!sent_q) begin
            req_q  <= 1'b1;
            sent_q <= 1'b1;
         end else if (cmd_done_i) begin
            sent_q <= 1'b0;
            if (bad) begin
               state  <= ST_IDLE;
               done_q <= 1'b1;
               err_q  <= 1'b1;
               type_q <= CARD_NONE;
               mult_q <= '0;
            end else begin
               state <= nxt;
               if (nxt == ST_V2_WAIT) go_q <= 1'b1;
               if (state == ST_V1_OP && nxt == ST_BLKLEN) begin
                  type_q <= CARD_V1;
                  mult_q <= MULT_W'(BLOCK_LEN);
               end
               if (state == ST_V2_OCR_FIN) begin
                  type_q <= cmd_ccs_i ? CARD_V2_HC : CARD_V2_SC;
                  mult_q <= MULT_W'(1);
               end
               if (state == ST_BLKLEN) begin
                  done_q <= 1'b1;
                  slow_q <= 1'b0;
               end
            end
         end
      end
   end

   assign busy_o      = (state != ST_IDLE);
   assign done_o      = done_q;
   assign err_o       = err_q;
   assign card_type_o = type_q;
   assign addr_mult_o = mult_q;
   assign slow_clk_o  = slow_q;
   assign cmd_req_o   = req_q;
   assign cmd_dummy_o = cmd.dummy;
   assign cmd_index_o = cmd.index;
   assign cmd_arg_o   = cmd.arg;
   assign cmd_crc_o   = cmd.crc;
   assign cmd_tail_o  = cmd.tail;

   // R1
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req_o |=> !cmd_req_o);

   // R10
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req_o |-> busy_o);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R8
   fast_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(slow_clk_o) |-> (done_o && !err_o));

   // R2
   fail_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> (card_type_o == 2'd0 && slow_clk_o));

   // R4
   v1_mult_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o && card_type_o == 2'd1) |-> (addr_mult_o == MULT_W'(BLOCK_LEN)));

   // R5
   v2_mult_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o && card_type_o[1]) |-> (addr_mult_o == MULT_W'(1)));

   // R7
   wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_V2_WAIT) |-> !cmd_req_o);

endmodule

// File: tb/sim_sd_init_seq.sv
module sim_sd_init_seq;

   localparam int MAXT  = 6;
   localparam int WAITC = 12;
   localparam int DUMB  = 16;
   localparam int BLEN  = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        busy_o, done_o, err_o, slow_clk_o;
   logic [1:0]  card_type_o;
   logic [9:0]  addr_mult_o;
   logic        cmd_req_o, cmd_dummy_o;
   logic [5:0]  cmd_index_o;
   logic [31:0] cmd_arg_o;
   logic [7:0]  cmd_crc_o;
   logic [2:0]  cmd_tail_o;
   logic        cmd_done_i = 1'b0;
   logic        cmd_tmo_i = 1'b0;
   logic [7:0]  cmd_r1_i = 8'hFF;
   logic        cmd_ccs_i = 1'b0;

   always #5 clk = ~clk;

   sd_init_seq #(.DUMMY_BYTES(DUMB), .MAX_TRIES(MAXT), .WAIT_CYC(WAITC), .BLOCK_LEN(BLEN)) u0 (
      .clk, .rst_n, .start_i, .busy_o, .done_o, .err_o, .card_type_o, .addr_mult_o,
      .slow_clk_o, .cmd_req_o, .cmd_dummy_o, .cmd_index_o, .cmd_arg_o, .cmd_crc_o,
      .cmd_tail_o, .cmd_done_i, .cmd_tmo_i, .cmd_r1_i, .cmd_ccs_i
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // scenario
   int sc_r0, sc_r8, sc_n, sc_r16, sc_tmo;
   bit sc_ccs;
   // observations
   int c_dmy, c0, c8, c55, c41, c58, c16, c_all, arg_bad, fast_req, min_gap;
   int last_done, prev_idx, prev_r1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // command engine model
   initial begin
      forever begin
         @(negedge clk);
         if (cmd_req_o) begin
            automatic int  r1 = 8'hFF;
            automatic bit  tmo = 1'b0;
            automatic int  idx = cmd_index_o;
            automatic int  dly = $urandom_range(1, 4);
            if (!slow_clk_o) fast_req++;
            if (cmd_dummy_o) begin
               c_dmy++;
               if (c_all != 0 || cmd_arg_o != DUMB) arg_bad++;
               r1 = 8'hFF;
               idx = -1;
            end else begin
               if (c_all == 0) arg_bad++;
               case (idx)
                  0: begin
                     c0++; r1 = sc_r0; tmo = (sc_tmo == 1);
                     if (cmd_arg_o != 0 || cmd_crc_o != 8'h95 || cmd_tail_o != 0) arg_bad++;
                  end
                  8: begin
                     c8++; r1 = sc_r8;
                     if (cmd_arg_o != 32'h1AA || cmd_crc_o != 8'h87 || cmd_tail_o != 4) arg_bad++;
                  end
                  55: begin
                     c55++; r1 = 8'h01; tmo = (sc_tmo == 2);
                     if (cmd_arg_o != 0 || cmd_tail_o != 0) arg_bad++;
                  end
                  41: begin
                     r1 = (c41 < sc_n) ? 8'h01 : 8'h00;
                     c41++;
                     if (cmd_arg_o != ((sc_r8 == 1) ? 32'h4000_0000 : 32'h0)) arg_bad++;
                  end
                  58: begin
                     c58++; r1 = 8'h01;
                     if (cmd_arg_o != 0 || cmd_tail_o != 4) arg_bad++;
                     if (prev_idx == 8 || (prev_idx == 41 && prev_r1 != 0))
                        if (cyc - last_done < min_gap) min_gap = cyc - last_done;
                  end
                  16: begin
                     c16++; r1 = sc_r16;
                     if (cmd_arg_o != BLEN || cmd_tail_o != 0) arg_bad++;
                  end
                  default: arg_bad++;
               endcase
            end
            c_all++;
            prev_idx = idx;
            prev_r1 = r1;
            repeat (dly) @(negedge clk);
            cmd_done_i = 1'b1;
            cmd_r1_i = 8'(r1);
            cmd_tmo_i = tmo;
            cmd_ccs_i = sc_ccs;
            last_done = cyc;
            @(negedge clk);
            cmd_done_i = 1'b0;
            cmd_tmo_i = 1'b0;
         end
      end
   end

   // tmo: 0 none, 1 on reset command, 2 on first index 55
   task automatic run_case(input int r0, input int r8, input int n, input bit ccs,
                           input int r16, input int tmo, input bit restart);
      int e_n41, e_n55, e_n58, e_n16, e_type, e_mult, t;
      bit e_fail, v2, v1;
      sc_r0 = r0; sc_r8 = r8; sc_n = n; sc_ccs = ccs; sc_r16 = r16; sc_tmo = tmo;
      c_dmy = 0; c0 = 0; c8 = 0; c55 = 0; c41 = 0; c58 = 0; c16 = 0; c_all = 0;
      arg_bad = 0; fast_req = 0; min_gap = 1000000; prev_idx = -2; prev_r1 = 0;
      // expected values from the requirements
      e_n41 = 0; e_n55 = 0; e_n58 = 0; e_n16 = 0; e_fail = 1'b0;
      v2 = 1'b0; v1 = 1'b0;
      if (tmo == 1 || r0 != 1) e_fail = 1'b1;
      else if (r8 == 1) v2 = 1'b1;
      else if (r8 == 5) v1 = 1'b1;
      else e_fail = 1'b1;
      if (v1 || v2) begin
         if (tmo == 2) begin
            e_n55 = 1; e_n58 = v2 ? 1 : 0; e_fail = 1'b1;
         end else begin
            e_n41 = (n >= MAXT) ? MAXT : n + 1;
            e_n55 = e_n41;
            e_n58 = v2 ? e_n41 : 0;
            if (n >= MAXT) e_fail = 1'b1;
            else begin
               if (v2) e_n58++;
               e_n16 = 1;
               if (r16 != 0) e_fail = 1'b1;
            end
         end
      end
      e_type = e_fail ? 0 : (v1 ? 1 : (ccs ? 3 : 2));
      e_mult = e_fail ? 0 : (v1 ? BLEN : 1);

      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      if (restart) begin
         repeat (5) @(negedge clk);
         start_i = 1'b1;            // R10: must be ignored while busy
         @(negedge clk); start_i = 1'b0;
      end
      t = 0;
      while (!done_o && t < 20000) begin @(negedge clk); t++; end
      chk(done_o, "R10 done seen", done_o, 1);
      chk(err_o == e_fail, "R2/R3/R6/R8/R9 err", err_o, e_fail);
      chk(card_type_o == e_type, "R4/R5 card type", card_type_o, e_type);
      chk(addr_mult_o == e_mult, "R4/R5 addr mult", addr_mult_o, e_mult);
      chk(slow_clk_o == e_fail, "R8 clock select", slow_clk_o, e_fail);
      chk(c_dmy == 1, "R1 R10 idle bursts", c_dmy, 1);
      chk(arg_bad == 0, "R1 R2 R3 R5 R8 request fields", arg_bad, 0);
      chk(fast_req == 0, "R1 slow clock on requests", fast_req, 0);
      chk(c41 == e_n41, "R4 R6 index41 count", c41, e_n41);
      chk(c55 == e_n55, "R4 R9 index55 count", c55, e_n55);
      chk(c58 == e_n58, "R5 index58 count", c58, e_n58);
      chk(c16 == e_n16, "R8 index16 count", c16, e_n16);
      if (v2 && e_n58 > 0)
         chk(min_gap >= WAITC, "R7 pause before attempt", min_gap, WAITC);
      @(negedge clk);
      chk(!done_o && !busy_o, "R10 done one cycle", done_o, 0);
      chk(err_o == e_fail, "R10 err held", err_o, e_fail);
   endtask

   initial begin
      #3_000_000;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy_o && !done_o && !err_o && !cmd_req_o, "R1 reset flags", busy_o, 0);
      chk(card_type_o == 0 && addr_mult_o == 0, "R1 reset type", card_type_o, 0);
      chk(slow_clk_o == 1'b1, "R1 reset clock", slow_clk_o, 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy_o && !cmd_req_o, "R1 idle without start", busy_o, 0);

      run_case(1, 5, 0, 0, 0, 0, 0);   // R4 older path, ready at once
      run_case(1, 5, 3, 0, 0, 0, 0);   // R4 older path, three retries
      run_case(1, 1, 2, 1, 0, 0, 0);   // R5 high capacity
      run_case(1, 1, 0, 0, 0, 0, 0);   // R5 standard capacity
      run_case(0, 5, 0, 0, 0, 0, 0);   // R2 bad reset reply
      run_case(1, 9, 0, 0, 0, 0, 0);   // R3 bad probe reply
      run_case(1, 5, MAXT, 0, 0, 0, 0);       // R6 older path limit
      run_case(1, 1, MAXT + 3, 1, 0, 0, 0);   // R6 newer path limit
      run_case(1, 5, MAXT - 1, 0, 0, 0, 0);   // R6 last attempt succeeds
      run_case(1, 1, 1, 1, 4, 0, 0);   // R8 block length refused
      run_case(1, 5, 0, 0, 0, 1, 0);   // R9 timeout on reset
      run_case(1, 1, 0, 0, 0, 2, 0);   // R9 timeout mid-loop
      run_case(1, 1, 1, 0, 0, 0, 1);   // R10 start while busy

      for (int i = 0; i < 20; i++) begin
         automatic int r0 = ($urandom_range(0, 9) == 0) ? 0 : 1;
         automatic int pk = $urandom_range(0, 9);
         automatic int r8 = (pk < 4) ? 5 : ((pk < 9) ? 1 : 8'h03);
         automatic int r16 = ($urandom_range(0, 7) == 0) ? 8'h40 : 0;
         run_case(r0, r8, $urandom_range(0, MAXT + 1), 1'($urandom_range(0, 1)),
                  r16, 0, 0);
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule